// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five privilege levels (localities 0 to 4) currently owns a shared register interface. Every locality sees its own 8-bit access register. Address bits 14:12 select the locality, and the low twelve address bits must be zero for the access register to be hit. Software writes these registers to do four things: ask for ownership, give ownership back, preempt a lower-numbered owner, or acknowledge that it was preempted.

The arbiter keeps these per-locality flags:

- active
- request pending
- preempted
- a hidden seize flag

It also holds the current owner number, where 0xFF means that no locality is active. Whenever a new locality takes ownership, it emits a one-cycle ownership-changed pulse. Some hand-overs take ownership away from a locality that may have a command running. When the command engine reports busy, such a hand-over is parked. The arbiter then raises an abort request to the engine, naming the owner being aborted. It commits the hand-over only when the engine returns an abort-done strobe. When the engine is idle, the hand-over commits in the same cycle as the write.

Access register layout, for both read and write:

| Bit | Meaning |
|-----|---------|
| 7 | register valid, always reads 1 |
| 5 | active; writing 1 releases ownership |
| 4 | preempted; writing 1 clears it |
| 3 | seize; write only, always reads 0 |
| 2 | pending; read only |
| 1 | request |

All other bits read as 0.

Top module: `locality_arbiter`

## Requirements
- R1: After reset no locality is active (`active_loc_o` = 0xFF), `abort_req_o` is low, and every access register reads 0x80.
- R2: A write with bit 1 set, made while no locality is active, makes the writer the owner on the next clock edge. It raises `loc_changed_o` for one cycle, and the owner's register reads with bit 5 set and bit 1 clear.
- R3: A write with bit 1 set, made while another locality owns the interface, sets the writer's request bit and leaves the owner unchanged. Reading any locality returns bit 2 = 1 exactly when some other locality has its request bit set.
- R4: The owner writing bit 5 while no request is pending leaves no locality active (0xFF), with no ownership-changed pulse.
- R5: The owner writing bit 5 while requests are pending hands ownership to the highest-numbered requester. That locality's request bit is cleared and the ownership-changed pulse is raised.
- R6: A locality that is not the owner writing bit 5 only clears its own request bit.
- R7: A write with bit 3 set takes ownership only when no locality is active or when the writer's number is above the owner's; otherwise it has no effect. The displaced owner loses bit 5 and gains bit 4, and bit 3 always reads 0.
- R8: A locality writing bit 4 clears its own preempted flag.
- R9: While `cmd_busy_i` is high, a hand-over raises `abort_req_o` with `abort_loc_o` set to the owner being aborted. The owner then stays unchanged until `abort_done_i`, after which the next owner is installed on the following edge and `abort_req_o` drops.
- R10: Access writes made while an abort is outstanding are ignored.
- R11: Writes that decode to locality 4 are ignored. So are writes with a non-zero register offset and writes that decode to a locality number above 4. Reads of locality 4 still work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| addr_i | input | 15 | bus address; bits 14:12 select the locality |
| wr_en_i | input | 1 | write strobe for the addressed access register |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | combinational read of the addressed access register; 0 when the address misses |
| cmd_busy_i | input | 1 | command engine is executing a command |
| abort_done_i | input | 1 | one-cycle strobe: the outstanding abort has finished |
| abort_req_o | output | 1 | hand-over is waiting for an abort |
| abort_loc_o | output | 8 | owner being aborted (0xFF if none) |
| active_loc_o | output | 8 | current owner, 0xFF when none |
| loc_changed_o | output | 1 | one-cycle pulse after a new locality becomes owner |

## Verification
The assertions assume three things about the inputs:

- `abort_done_i` is only pulsed while `abort_req_o` is high.
- `cmd_busy_i` is only changed while no hand-over is outstanding.
- Writes are single-cycle strobes.

The stimulus drives every input on the falling edge. It holds `cmd_busy_i` steady around each hand-over and pulses `abort_done_i` only after observing `abort_req_o` high. Ownership-changed pulses are checked against a queue of expected new owners that the driver fills before each write that should cause one.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
  localparam int unsigned ID_W = 8;
  localparam logic [ID_W-1:0] NO_LOC = 8'hFF;
  // access register bit positions
  localparam int unsigned B_REQ  = 1;
  localparam int unsigned B_PEND = 2;
  localparam int unsigned B_SEIZ = 3;
  localparam int unsigned B_LOST = 4;
  localparam int unsigned B_ACT  = 5;
  localparam int unsigned B_VLD  = 7;
endpackage

// File: rtl/locarb_decode.sv
module locarb_decode #(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned LOC_LSB = 12,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned N_LOC   = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LOC_W-1:0]  loc_o,
  output logic              rd_hit_o,
  output logic              wr_ok_o
);
  logic off_zero, loc_ok;
  assign loc_o    = addr_i[LOC_LSB +: LOC_W];
  assign off_zero = (addr_i[LOC_LSB-1:0] == '0);
  assign loc_ok   = ({1'b0, loc_o} < (LOC_W+1)'(N_LOC));
  assign rd_hit_o = off_zero && loc_ok;
  // top locality is read-only on this interface
  assign wr_ok_o  = rd_hit_o && (loc_o != LOC_W'(N_LOC-1));
endmodule

// File: rtl/locarb_pending.sv
module locarb_pending #(
  parameter int unsigned N_LOC = 5
) (
  input  logic [N_LOC-1:0] req_i,
  output logic [N_LOC-1:0] pend_o
);
  for (genvar g = 0; g < N_LOC; g++) begin : g_pend
    logic [N_LOC-1:0] others;
    always_comb begin
      others    = req_i;
      others[g] = 1'b0;
    end
    assign pend_o[g] = |others;
  end
endmodule

// File: rtl/locarb_ctrl.sv
module locarb_ctrl
  import locarb_pkg::*;
#(
  parameter int unsigned N_LOC = 5,
  parameter int unsigned LOC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [LOC_W-1:0]  wr_loc_i,
  input  logic [7:0]        wdata_i,
  input  logic              cmd_busy_i,
  input  logic              abort_done_i,
  output logic [N_LOC-1:0]  req_o,
  output logic [N_LOC-1:0]  act_o,
  output logic [N_LOC-1:0]  lost_o,
  output logic [ID_W-1:0]   active_o,
  output logic              changed_o,
  output logic              abort_req_o,
  output logic [ID_W-1:0]   abort_loc_o
);
  logic [N_LOC-1:0] req_q, req_d, seiz_q, seiz_d, act_q, act_d, lost_q, lost_d;
  logic [ID_W-1:0]  active_q, active_d, next_q, next_d, abt_q, abt_d;
  logic             pend_q, pend_d, chg_q, chg_d;

  logic [ID_W-1:0] wl;
  logic            act_valid;
  assign wl        = ID_W'(wr_loc_i);
  assign act_valid = active_q < ID_W'(N_LOC);

  always_comb begin
    logic [7:0]      v;
    logic            set_new, start_ab, do_commit, higher, found_ok, is_seize;
    logic [ID_W-1:0] new_act, nxt, abt, commit_id, found_id;
    req_d = req_q; seiz_d = seiz_q; act_d = act_q; lost_d = lost_q;
    active_d = active_q; next_d = next_q; abt_d = abt_q; pend_d = pend_q;
    chg_d = 1'b0;
    v = wdata_i; set_new = 1'b0; start_ab = 1'b0; do_commit = 1'b0;
    higher = 1'b0; found_ok = 1'b0; is_seize = 1'b0;
    new_act = active_q; nxt = NO_LOC; abt = NO_LOC; commit_id = active_q;
    found_id = NO_LOC;

    if (pend_q && abort_done_i) begin
      do_commit = 1'b1;
      commit_id = next_q;
      pend_d    = 1'b0;
      next_d    = NO_LOC;
      abt_d     = NO_LOC;
    end else if (wr_i && !pend_q) begin
      set_new = 1'b1;
      if (v[B_SEIZ]) begin
        v[B_REQ] = 1'b0;
        v[B_ACT] = 1'b0;
      end
      if (v[B_ACT]) begin
        if (active_q == wl) begin
          for (int i = 0; i < N_LOC; i++)
            if (req_q[i]) begin
              found_ok = 1'b1;
              found_id = ID_W'(i);
            end
          if (found_ok) begin
            set_new  = 1'b0;
            start_ab = 1'b1;
            nxt      = found_id;
            abt      = wl;
          end else begin
            new_act = NO_LOC;
          end
        end else begin
          req_d[wr_loc_i] = 1'b0;
        end
      end
      if (v[B_LOST]) lost_d[wr_loc_i] = 1'b0;
      if (v[B_SEIZ] && (!act_valid || wl > active_q) && !seiz_q[wr_loc_i]) begin
        for (int i = 0; i < N_LOC; i++)
          if (i > int'(wr_loc_i) && seiz_q[i]) higher = 1'b1;
        if (!higher) begin
          for (int i = 0; i < N_LOC; i++)
            if (i < int'(wr_loc_i)) seiz_d[i] = 1'b0;
          seiz_d[wr_loc_i] = 1'b1;
          set_new  = 1'b0;
          start_ab = 1'b1;
          nxt      = wl;
          abt      = active_q;
        end
      end
      if (v[B_REQ] && active_q != wl) begin
        if (act_valid) req_d[wr_loc_i] = 1'b1;
        else           new_act = wl;
      end
      if (set_new) begin
        do_commit = 1'b1;
        commit_id = new_act;
      end
      if (start_ab) begin
        if (cmd_busy_i) begin
          pend_d = 1'b1;
          next_d = nxt;
          abt_d  = abt;
        end else begin
          do_commit = 1'b1;
          commit_id = nxt;
        end
      end
    end

    if (do_commit) begin
      if (commit_id != active_q) begin
        if (act_valid) begin
          is_seize = (commit_id < ID_W'(N_LOC)) && seiz_d[commit_id[LOC_W-1:0]];
          act_d[active_q[LOC_W-1:0]] = 1'b0;
          if (is_seize) lost_d[active_q[LOC_W-1:0]] = 1'b1;
          else          req_d[active_q[LOC_W-1:0]]  = 1'b0;
        end
        chg_d = (commit_id < ID_W'(N_LOC));
      end
      active_d = commit_id;
      if (commit_id < ID_W'(N_LOC)) begin
        act_d[commit_id[LOC_W-1:0]]  = 1'b1;
        req_d[commit_id[LOC_W-1:0]]  = 1'b0;
        seiz_d[commit_id[LOC_W-1:0]] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0; seiz_q <= '0; act_q <= '0; lost_q <= '0;
      active_q <= NO_LOC; next_q <= NO_LOC; abt_q <= NO_LOC;
      pend_q <= 1'b0; chg_q <= 1'b0;
    end else begin
      req_q <= req_d; seiz_q <= seiz_d; act_q <= act_d; lost_q <= lost_d;
      active_q <= active_d; next_q <= next_d; abt_q <= abt_d;
      pend_q <= pend_d; chg_q <= chg_d;
    end
  end

  assign req_o       = req_q;
  assign act_o       = act_q;
  assign lost_o      = lost_q;
  assign active_o    = active_q;
  assign changed_o   = chg_q;
  assign abort_req_o = pend_q;
  assign abort_loc_o = abt_q;

  assert_single_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_q));
  assert_idle_no_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q == NO_LOC) |-> (act_q == '0));
  assert_event_has_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> (active_q != NO_LOC));
  assert_hold_owner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !abort_done_i) |=> $stable(active_q));
  assert_commit_next_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && abort_done_i) |=> (active_q == $past(next_q)) && !pend_q);
  assert_ignore_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !abort_done_i) |=> $stable(req_q) && $stable(lost_q));
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import locarb_pkg::*;
#(
  parameter int unsigned N_LOC   = 5,
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned LOC_LSB = 12,
  parameter int unsigned LOC_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              cmd_busy_i,
  input  logic              abort_done_i,
  output logic              abort_req_o,
  output logic [ID_W-1:0]   abort_loc_o,
  output logic [ID_W-1:0]   active_loc_o,
  output logic              loc_changed_o
);
  logic [LOC_W-1:0] loc;
  logic             rd_hit, wr_ok;
  logic [N_LOC-1:0] req, act, lost, pend;

  locarb_decode #(.ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .LOC_W(LOC_W), .N_LOC(N_LOC))
    u_dec (.addr_i(addr_i), .loc_o(loc), .rd_hit_o(rd_hit), .wr_ok_o(wr_ok));

  locarb_ctrl #(.N_LOC(N_LOC), .LOC_W(LOC_W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i && wr_ok), .wr_loc_i(loc), .wdata_i,
    .cmd_busy_i, .abort_done_i,
    .req_o(req), .act_o(act), .lost_o(lost),
    .active_o(active_loc_o), .changed_o(loc_changed_o),
    .abort_req_o, .abort_loc_o
  );

  locarb_pending #(.N_LOC(N_LOC)) u_pend (.req_i(req), .pend_o(pend));

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < N_LOC; i++) begin
      if (rd_hit && loc == LOC_W'(i)) begin
        rdata_o[B_VLD]  = 1'b1;
        rdata_o[B_ACT]  = act[i];
        rdata_o[B_LOST] = lost[i];
        rdata_o[B_PEND] = pend[i];
        rdata_o[B_REQ]  = req[i];
      end
    end
  end

  assert_top_loc_ro_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !abort_req_o && loc == LOC_W'(N_LOC-1)) |=> $stable(active_loc_o));
  assert_miss_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_hit && !abort_req_o) |=> $stable(active_loc_o));
endmodule

// File: tb/locality_arbiter_test.sv
module locality_arbiter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic        wr_en = 1'b0, busy = 1'b0, done = 1'b0;
  logic [7:0]  wdata = '0, rdata, abort_loc, active;
  logic        abort_req, changed;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;
  logic [7:0]  exp_q[$];

  always #5 clk = ~clk;

  locality_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .cmd_busy_i(busy), .abort_done_i(done),
    .abort_req_o(abort_req), .abort_loc_o(abort_loc),
    .active_loc_o(active), .loc_changed_o(changed)
  );

  task automatic check(string req, logic [7:0] act_v, logic [7:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // monitor: each ownership-changed pulse pops the expected new owner
  always @(negedge clk) begin
    if (rst_n && changed && !finished) begin
      if (exp_q.size() == 0) check("R5 unexpected change", active, 8'hEE);
      else check("R5 change owner", active, exp_q.pop_front());
    end
  end

  task automatic wr(int loc, logic [7:0] d, logic [11:0] off = '0);
    @(negedge clk);
    addr = {3'(loc), off}; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, int loc, logic [7:0] exp_v);
    addr = {3'(loc), 12'h000};
    #1;
    check(req, rdata, exp_v);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 idle owner", active, 8'hFF);
    check("R1 abort low", {7'b0, abort_req}, 8'h00);
    for (int i = 0; i < 5; i++) rd("R1 reset value", i, 8'h80);

    // R2
    exp_q.push_back(8'd1);
    wr(1, 8'h02);
    check("R2 owner", active, 8'd1);
    rd("R2 owner reg", 1, 8'hA0);

    // R3
    wr(0, 8'h02);
    wr(3, 8'h02);
    check("R3 owner kept", active, 8'd1);
    rd("R3 req0", 0, 8'h86);
    rd("R3 owner pend", 1, 8'hA4);
    rd("R3 bystander", 2, 8'h84);
    rd("R3 req3", 3, 8'h86);

    // R6
    wr(0, 8'h20);
    rd("R6 req cleared", 0, 8'h84);
    rd("R6 other req", 3, 8'h82);

    // R5 highest requester wins
    wr(2, 8'h02);
    exp_q.push_back(8'd3);
    wr(1, 8'h20);
    check("R5 owner 3", active, 8'd3);
    rd("R5 new owner", 3, 8'hA4);
    rd("R5 old owner", 1, 8'h84);
    exp_q.push_back(8'd2);
    wr(3, 8'h20);
    check("R5 owner 2", active, 8'd2);
    rd("R5 owner2 reg", 2, 8'hA0);

    // R4
    wr(2, 8'h20);
    check("R4 none", active, 8'hFF);
    rd("R4 reg", 2, 8'h80);

    // R7 seize with none active
    exp_q.push_back(8'd2);
    wr(2, 8'h08);
    check("R7 seize idle", active, 8'd2);
    rd("R7 seize hidden", 2, 8'hA0);
    wr(1, 8'h02);
    wr(1, 8'h08);
    check("R7 lower seize rejected", active, 8'd2);
    rd("R7 lower reg", 1, 8'h82);
    exp_q.push_back(8'd3);
    wr(3, 8'h08);
    check("R7 higher seize", active, 8'd3);
    rd("R7 loser reg", 2, 8'h94);
    rd("R7 winner reg", 3, 8'hA4);

    // R8
    wr(2, 8'h10);
    rd("R8 lost cleared", 2, 8'h84);

    // R9 / R10
    busy = 1'b1;
    wr(3, 8'h20);
    check("R9 abort req", {7'b0, abort_req}, 8'h01);
    check("R9 abort loc", abort_loc, 8'd3);
    repeat (3) @(negedge clk);
    check("R9 held", active, 8'd3);
    wr(0, 8'h02);
    rd("R10 ignored", 0, 8'h84);
    exp_q.push_back(8'd1);
    pulse_done();
    check("R9 committed", active, 8'd1);
    check("R9 abort dropped", {7'b0, abort_req}, 8'h00);
    rd("R9 new owner", 1, 8'hA0);
    rd("R9 old owner", 3, 8'h80);
    busy = 1'b0;

    // R11
    wr(4, 8'h02);
    rd("R11 loc4 ignored", 4, 8'h80);
    rd("R11 owner no pend", 1, 8'hA0);
    wr(1, 8'h20, 12'h004);
    check("R11 offset ignored", active, 8'd1);

    // R7 + R9 seize across a busy engine
    busy = 1'b1;
    wr(3, 8'h08);
    check("R9 seize parked", abort_loc, 8'd1);
    check("R9 seize held", active, 8'd1);
    exp_q.push_back(8'd3);
    pulse_done();
    busy = 1'b0;
    check("R7 busy seize owner", active, 8'd3);
    rd("R7 busy loser", 1, 8'h90);
    rd("R7 busy winner", 3, 8'hA0);

    repeat (2) @(negedge clk);
    check("R5 all changes seen", 8'(exp_q.size()), 8'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule